// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is a single DMA channel that walks a chain of descriptors held in memory. Each descriptor is seven 32-bit words. The channel reads a descriptor from a 64-byte aligned pointer and then moves a block of data units. The data flows either from RAM to a peripheral data port or from that port to RAM. When the block is done, the channel follows the descriptor's next link if that link is tagged valid. A chain whose last link points back to an earlier descriptor therefore runs until software stops it.

Software controls the channel through three pulses:

- `start` begins a walk at a given pointer.
- `stop` halts the channel at the next unit boundary.
- `query` makes the channel write an image of its live descriptor to a given RAM address.

The image carries the next link, the current source address and the remaining length. It is laid out like a real descriptor, so a later `start` at the image address resumes the transfer exactly where it left off. The channel can raise a one-cycle interrupt pulse as each descriptor completes.

Top module: `lldma_chan`

## Requirements
- R1: The descriptor words are read in the order next, source, destination, length, stride, cycles and command, at byte offsets 0, 4, 8, 12, 16, 20 and 24 from the pointer. The pointer's low 6 bits are ignored when it is used.
- R2: If command bit 12 is 1, each unit is read from RAM at the current source address and offered on `per_wdata`. `per_addr` shows the destination word.
- R3: If command bit 12 is 0, each unit is taken from `per_rdata` and written to RAM at the current source address.
- R4: The length word counts units, not bytes. After each unit the source address advances by 1, 2 or 4 for `width_sel` values 0, 1 and 2. The value 3 also advances by 4.
- R5: A descriptor with length 0 completes without moving any data.
- R6: If bit 0 of the next word is 1, the next descriptor is fetched at that word with its low 6 bits cleared. If bit 0 is 0, the channel goes idle and `busy` drops.
- R7: `irq` pulses for exactly one cycle per completed descriptor whose command has bit 1 set and bit 0 clear. It does not pulse otherwise.
- R8: A circular chain keeps transferring past the sum of its lengths until a stop arrives.
- R9: A stop takes effect only at a unit boundary, after the unit in flight completes. A stop while idle has no effect.
- R10: A query writes seven words to the query address (low 6 bits ignored), in the R1 order. Word 1 is the current source address and word 3 is the remaining length. When a query and a stop are pending together, the image is written before the channel halts. A query while idle writes the last state.
- R11: Starting at a written image resumes the transfer. The total number of units moved equals the original length, and the data is the same as for an uninterrupted run.
- R12: A memory request holds its address, direction and write data until `mem_ack`. A peripheral write holds its data until `per_wready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin walking at `start_ptr` (ignored when busy) |
| start_ptr | input | AW | Descriptor pointer for start or resume |
| stop | input | 1 | Pulse: halt at the next unit boundary |
| query | input | 1 | Pulse: write the live descriptor image |
| query_ptr | input | AW | RAM address for the image |
| width_sel | input | 2 | Unit size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| per_addr | output | 32 | Peripheral address from the descriptor |
| per_wvalid | output | 1 | Data offered to the peripheral |
| per_wdata | output | 32 | Data to the peripheral |
| per_wready | input | 1 | Peripheral accepts the data |
| per_rvalid | input | 1 | Peripheral has data |
| per_rdata | input | 32 | Data from the peripheral |
| per_rready | output | 1 | Channel takes peripheral data |
| busy | output | 1 | A walk is in progress |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check five properties on every cycle:

- memory requests and peripheral writes hold steady until accepted;
- an interrupt never lasts two cycles;
- descriptor fetches start on an aligned address;
- no data moves while the channel is idle;
- no data moves while the remaining length is zero.

The bench scenarios show the behaviours that depend on the data itself:

- the words delivered for each unit size;
- RAM contents written from the peripheral;
- link following and interrupt masking across a chain;
- a circular chain that outlives its total length;
- the exact contents of a query image;
- a resume that completes the original transfer without gaps or repeats.

// File: rtl/lldma_chan.sv
module lldma_chan #(
  parameter int AW    = 32,
  parameter int ALIGN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_ptr,
  input  logic          stop,
  input  logic          query,
  input  logic [AW-1:0] query_ptr,
  input  logic [1:0]    width_sel,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   per_addr,
  output logic          per_wvalid,
  output logic [31:0]   per_wdata,
  input  logic          per_wready,
  input  logic          per_rvalid,
  input  logic [31:0]   per_rdata,
  output logic          per_rready,
  output logic          busy,
  output logic          irq
);
  localparam int NW = 7;
  localparam int IW = $clog2(NW);

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_BOUND, S_MRD, S_PWR, S_PRD, S_MWR, S_DONE, S_WB
  } st_t;

  st_t            state;
  logic [IW-1:0]  idx;
  logic [31:0]    dw [NW];
  logic [AW-1:0]  ptr, qaddr;
  logic           q_pend, stop_pend, wb_idle;
  logic [31:0]    data_q;
  logic [AW-1:0]  step, word_off;
  logic           last_word, unit_done;

  function automatic logic [AW-1:0] align_dn(input logic [AW-1:0] a);
    return {a[AW-1:ALIGN], {ALIGN{1'b0}}};
  endfunction

  assign step      = (width_sel == 2'd0) ? AW'(1) : (width_sel == 2'd1) ? AW'(2) : AW'(4);
  assign word_off  = AW'({idx, 2'b00});
  assign last_word = (idx == IW'(NW - 1));
  assign unit_done = (state == S_PWR && per_wready) || (state == S_MWR && mem_ack);

  assign mem_req    = state inside {S_FETCH, S_MRD, S_MWR, S_WB};
  assign mem_we     = state inside {S_MWR, S_WB};
  assign mem_addr   = (state == S_FETCH) ? ptr + word_off :
                      (state == S_WB)    ? qaddr + word_off : dw[1][AW-1:0];
  assign mem_wdata  = (state == S_WB) ? dw[idx] : data_q;
  assign per_addr   = dw[2];
  assign per_wvalid = (state == S_PWR);
  assign per_wdata  = data_q;
  assign per_rready = (state == S_PRD);
  assign busy       = !(state == S_IDLE || (state == S_WB && wb_idle));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      for (int i = 0; i < NW; i++) dw[i] <= '0;
      ptr       <= '0;
      qaddr     <= '0;
      q_pend    <= 1'b0;
      stop_pend <= 1'b0;
      wb_idle   <= 1'b0;
      data_q    <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop && busy) stop_pend <= 1'b1;
      if (query && !q_pend) begin
        q_pend <= 1'b1;
        qaddr  <= align_dn(query_ptr);
      end
      if (unit_done) begin
        dw[1] <= dw[1] + 32'(step);
        dw[3] <= dw[3] - 32'd1;
      end
      case (state)
        S_IDLE: begin
          stop_pend <= 1'b0;
          if (start) begin
            ptr   <= align_dn(start_ptr);
            idx   <= '0;
            state <= S_FETCH;
          end else if (q_pend) begin
            wb_idle <= 1'b1;
            idx     <= '0;
            state   <= S_WB;
          end
        end
        S_FETCH: if (mem_ack) begin
          dw[idx] <= mem_rdata;
          if (last_word) state <= S_BOUND;
          else idx <= idx + 1'b1;
        end
        S_BOUND: begin
          if (q_pend) begin
            wb_idle <= 1'b0;
            idx     <= '0;
            state   <= S_WB;
          end else if (dw[3] == 32'd0) begin
            state <= S_DONE;
          end else if (stop_pend) begin
            stop_pend <= 1'b0;
            state     <= S_IDLE;
          end else begin
            state <= dw[6][12] ? S_MRD : S_PRD;
          end
        end
        S_MRD: if (mem_ack) begin
          data_q <= mem_rdata;
          state  <= S_PWR;
        end
        S_PWR: if (per_wready) state <= S_BOUND;
        S_PRD: if (per_rvalid) begin
          data_q <= per_rdata;
          state  <= S_MWR;
        end
        S_MWR: if (mem_ack) state <= S_BOUND;
        S_DONE: begin
          irq <= dw[6][1] & ~dw[6][0];
          if (!stop_pend && dw[0][0]) begin
            ptr   <= align_dn(dw[0][AW-1:0]);
            idx   <= '0;
            state <= S_FETCH;
          end else begin
            stop_pend <= 1'b0;
            state     <= S_IDLE;
          end
        end
        S_WB: if (mem_ack) begin
          if (last_word) begin
            q_pend <= 1'b0;
            state  <= wb_idle ? S_IDLE : S_BOUND;
          end else idx <= idx + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fetch_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && idx == '0) |-> (mem_addr[ALIGN-1:0] == '0 && !mem_we));

  assert_zero_len_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wvalid || per_rready) |-> (dw[3] != 32'd0));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!per_wvalid && !per_rready));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_pw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wvalid && !per_wready) |=> (per_wvalid && $stable(per_wdata)));
endmodule

// File: tb/tb_lldma_chan.sv
`timescale 1ns/1ps
module tb_lldma_chan;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, stop = 0, query = 0;
  logic [31:0] start_ptr = 0, query_ptr = 0;
  logic [1:0]  width_sel = 2;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] per_addr, per_wdata, per_rdata;
  logic        per_wvalid, per_wready, per_rvalid, per_rready;
  logic        busy, irq;

  logic [31:0] mem [0:255];
  logic [31:0] plog [0:255];
  logic [31:0] paddr_seen;
  int          pcount = 0, icount = 0;
  logic [31:0] pseq = 32'hC0DE0000;
  logic        slow = 0, gate = 1;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  lldma_chan dut (.*);

  assign mem_ack    = mem_req & gate;
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign per_wready = gate;
  assign per_rvalid = gate;
  assign per_rdata  = pseq;

  always @(posedge clk) begin
    gate <= slow ? ~gate : 1'b1;
    if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (per_wvalid && per_wready) begin
      plog[pcount[7:0]] <= per_wdata;
      paddr_seen <= per_addr;
      pcount <= pcount + 1;
    end
    if (per_rready && per_rvalid) pseq <= pseq + 1;
    if (irq) icount <= icount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_desc(input int w, input logic [31:0] nxt, src, dst, len, cmd);
    mem[w] = nxt; mem[w+1] = src; mem[w+2] = dst; mem[w+3] = len;
    mem[w+4] = 0; mem[w+5] = 1; mem[w+6] = cmd;
  endtask

  task automatic wait_idle();
    for (int c = 0; c < 20000 && busy; c++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic go(input logic [31:0] p);
    @(negedge clk); start_ptr = p; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
  endtask

  task automatic fill();
    for (int i = 0; i < 256; i++) mem[i] = 32'hA0000000 + i;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int pb, ib, n, inc;
    fill();
    repeat (3) @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset mem_req", mem_req, 0);
    chk("reset irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R4 R7: RAM to device, 4-byte units, irq enabled
    set_desc(0, 0, 32'h200, 32'h3F0, 5, 32'h1002);
    pb = pcount; ib = icount; width_sel = 2;
    go(0);
    chk("R2 unit count", pcount - pb, 5);
    for (int k = 0; k < 5; k++) chk("R2 data", plog[pb+k], 32'hA0000000 + 128 + k);
    chk("R2 per_addr", paddr_seen, 32'h3F0);
    chk("R7 irq count", icount - ib, 1);
    chk("R6 busy dropped", busy, 0);

    // R4 width sweep, irq disabled (R7)
    for (int w = 0; w < 4; w++) begin
      inc = (w == 0) ? 1 : (w == 1) ? 2 : 4;
      set_desc(0, 0, 32'h204, 32'h3F0, 6, 32'h1000);
      pb = pcount; ib = icount; width_sel = w[1:0];
      go(0);
      chk("R4 count", pcount - pb, 6);
      for (int k = 0; k < 6; k++)
        chk("R4 data", plog[pb+k], 32'hA0000000 + ((32'h204 + k*inc) >> 2));
      chk("R7 no irq when bit1 clear", icount - ib, 0);
    end
    width_sel = 2;

    // R3: device to RAM
    set_desc(0, 0, 32'h300, 32'h3F0, 4, 32'h0002);
    begin
      logic [31:0] s0;
      s0 = pseq; pb = pcount;
      go(0);
      for (int k = 0; k < 4; k++) chk("R3 ram data", mem[192+k], s0 + k);
      chk("R3 no peripheral writes", pcount - pb, 0);
    end
    fill();

    // R1 R5 R6 R7: chain with junk low bits, zero-length middle, masked last
    set_desc(0,  32'h043, 32'h200, 32'h3F0, 2, 32'h1002);
    set_desc(16, 32'h0BD, 32'h220, 32'h3F0, 0, 32'h1002);
    set_desc(32, 32'h000, 32'h240, 32'h3F0, 3, 32'h1003);
    pb = pcount; ib = icount;
    go(32'h00C);
    chk("R6 chain units", pcount - pb, 5);
    chk("R1 first desc data", plog[pb], 32'hA0000000 + 128);
    chk("R5 zero-length skipped", plog[pb+2], 32'hA0000000 + 144);
    chk("R6 last desc data", plog[pb+4], 32'hA0000000 + 146);
    chk("R7 irq masked/enabled", icount - ib, 2);

    // R8: circular chain until stop
    set_desc(0,  32'h041, 32'h200, 32'h3F0, 2, 32'h1000);
    set_desc(16, 32'h001, 32'h280, 32'h3F0, 2, 32'h1000);
    pb = pcount;
    @(negedge clk); start_ptr = 0; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 5000 && (pcount - pb) < 11; c++) @(negedge clk);
    stop = 1; @(negedge clk); stop = 0;
    wait_idle();
    n = pcount - pb;
    chk("R8 ran past chain length", n >= 11, 1);
    for (int k = 0; k < 11; k++)
      chk("R8 loop data", plog[pb+k],
          32'hA0000000 + (((k/2)%2) ? 160 : 128) + (k%2));
    repeat (20) @(negedge clk);
    chk("R9 halted", pcount - pb, n);

    // R9 R10 R11: query + stop mid-transfer, then resume
    set_desc(0, 32'h0, 32'h200, 32'h3F0, 20, 32'h1000);
    pb = pcount; slow = 1;
    @(negedge clk); start_ptr = 0; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 5000 && (pcount - pb) < 7; c++) @(negedge clk);
    query_ptr = 32'h100; query = 1; stop = 1;
    @(negedge clk); query = 0; stop = 0;
    wait_idle();
    n = pcount - pb;
    chk("R9 stopped at boundary", (n >= 7 && n <= 8), 1);
    chk("R10 img next", mem[64], 0);
    chk("R10 img src", mem[65], 32'h200 + 4*n);
    chk("R10 img dst", mem[66], 32'h3F0);
    chk("R10 img len", mem[67], 20 - n);
    chk("R10 img stride", mem[68], 0);
    chk("R10 img cycles", mem[69], 1);
    chk("R10 img cmd", mem[70], 32'h1000);
    go(32'h100);
    slow = 0;
    chk("R11 total units", pcount - pb, 20);
    for (int k = 0; k < 20; k++) chk("R11 data", plog[pb+k], 32'hA0000000 + 128 + k);

    // R10: query while idle writes last state
    @(negedge clk); query_ptr = 32'h147; query = 1;
    @(negedge clk); query = 0;
    repeat (20) @(negedge clk);
    chk("R10 idle img len", mem[83], 0);
    chk("R10 idle img src", mem[81], 32'h200 + 80);
    chk("R10 idle busy", busy, 0);

    // R9: stop while idle ignored
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    repeat (5) @(negedge clk);
    chk("R9 idle stop no req", mem_req, 0);
    set_desc(0, 0, 32'h200, 32'h3F0, 2, 32'h1000);
    pb = pcount;
    go(0);
    chk("R9 idle stop not latched", pcount - pb, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule